// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. It derives a conversion tick either from a free-running divider on the system clock or from an externally supplied RC-oscillator tick. A 3-bit select field picks the source. Every other part of the converter is outside the block: the comparator drives `cmp_hi`, the capacitor DAC takes `dac_code`, and the sample switch takes `hold_open`.

Software starts a conversion by pulsing `start_req`. The block then raises `go` and opens the sample switch. It waits for the next conversion tick, which marks the start of the first period, and then runs eleven periods. The first period stages the top trial bit, and each of the ten periods after it decides one bit, from bit 9 down to bit 0.

One system clock after the final tick, four things happen in the same cycle: the result bytes are loaded, `go` drops, the done flag is set and the sample switch closes. Pulsing `stop_req` during a conversion abandons it and leaves no trace in the result or the flag.

Top module: `sar_conv_ctrl`

## Requirements
- R1: The tick divisor follows `clk_sel`: 000 gives 2, 100 gives 4, 001 gives 8, 101 gives 16, 010 gives 32 and 110 gives 64 system clocks. Any code with `clk_sel[1:0]`=11 uses the `rc_tick` pulses instead. A system-derived tick is never high in two consecutive cycles.
- R2: A conversion spans the first tick after the start plus eleven further ticks. In RC mode, with ticks supplied only by the bench, nothing completes before the 12th pulse, and completion is visible one clock after it. In divider mode with divisor D, the done flag is visible between 11D+2 and 12D+1 clocks after the start edge.
- R3: The second tick sets `dac_code` to 0x200. Every later tick keeps the current trial bit only if `cmp_hi` is 1 (input at or above the DAC level) and sets the next lower bit. The final result equals the input code, including 0 and 1023.
- R4: `hold_open` rises together with `go` at the start, before any tick.
- R5: In a single cycle, the result bytes are loaded, `go` falls, `done_flag` rises and `hold_open` falls. The result changes at no other time.
- R6: The result is right-justified: `res_hi` = {6'b0, bits 9:8} and `res_lo` = bits 7:0.
- R7: A `start_req` pulse while `go` is high has no effect, and the running conversion completes on its original schedule with the correct result.
- R8: A `stop_req` pulse while `go` is high clears `go` and `hold_open` on the next clock. The result and `done_flag` keep their values, and later ticks do nothing.
- R9: While `sys_halt` is high, the divider produces no ticks. A conversion in divider mode stalls, while one in RC mode completes.
- R10: `done_flag` stays set until a `flag_clr` pulse clears it.
- R11: After reset, `go`, `hold_open`, `done_flag`, `dac_code`, `res_hi` and `res_lo` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 3 | Conversion clock select |
| sys_halt | input | 1 | System clock halted (sleep): freezes the divider |
| rc_tick | input | 1 | One-cycle pulse per RC-oscillator period |
| start_req | input | 1 | Pulse: software sets the start bit |
| stop_req | input | 1 | Pulse: software clears the start bit |
| flag_clr | input | 1 | Pulse: clear the done flag |
| cmp_hi | input | 1 | Comparator: analog input at or above DAC level |
| go | output | 1 | Start bit, high while converting |
| hold_open | output | 1 | Sample switch open (input disconnected) |
| dac_code | output | 10 | Trial code driven to the capacitor DAC |
| done_flag | output | 1 | Conversion-complete interrupt flag |
| res_hi | output | 8 | Upper result byte |
| res_lo | output | 8 | Lower result byte |

## Verification
The bench builds the block with its defaults: a 10-bit result and a 6-bit divider. With these, all six divider settings and both RC codes can be selected, and every conversion makes all ten bit decisions. In RC mode the bench supplies every tick itself, which makes the frame length exact to the cycle and makes the bit-by-bit DAC trace predictable. The divider latency windows for neighbouring settings do not overlap, so any swap in the select decoding appears as a latency outside its window.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CONV,
        ST_FIN
    } sar_st_e;

    // Codes with both low bits set route the RC tick.
    function automatic logic sel_is_rc(input logic [2:0] code);
        return code[1:0] == 2'b11;
    endfunction

    // Divider exponent: 000->1, 100->2, 001->3, 101->4, 010->5, 110->6.
    function automatic logic [31:0] sel_shift(input logic [2:0] code);
        return {29'd0, code[1:0], 1'b0} + {31'd0, code[2]} + 32'd1;
    endfunction

endpackage

// File: rtl/sar_clkgen.sv
module sar_clkgen
    import sar_pkg::*;
#(
    parameter int MAX_SHIFT = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    input  logic       sys_halt,
    input  logic       rc_tick,
    output logic       conv_tick
);
    localparam int CNT_W = MAX_SHIFT;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } clk_reg_t;

    clk_reg_t         q, d;
    logic [CNT_W-1:0] mask;
    logic             sys_tick;

    always_comb begin
        d = q;
        if (!sys_halt) d.cnt = q.cnt + CNT_W'(1);
        mask      = CNT_W'((32'd1 << sel_shift(clk_sel)) - 32'd1);
        sys_tick  = !sys_halt && ((q.cnt & mask) == mask);
        conv_tick = sel_is_rc(clk_sel) ? rc_tick : sys_tick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Every divisor is at least 2, so ticks are never back to back.
    assert_tick_spaced_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sys_tick |=> !sys_tick);

    assert_halt_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_halt && !sel_is_rc(clk_sel)) |-> !conv_tick);

endmodule

// File: rtl/sar_seq_core.sv
module sar_seq_core
    import sar_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             flag_clr,
    input  logic             cmp_hi,
    output logic             go,
    output logic             hold_open,
    output logic             done_flag,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result
);
    localparam int IDX_W = $clog2(RES_W + 1);

    typedef struct packed {
        sar_st_e          st;
        logic             go;
        logic             hold;
        logic             flag;
        logic [IDX_W-1:0] idx;
        logic [RES_W-1:0] trial;
        logic [RES_W-1:0] res;
    } core_reg_t;

    core_reg_t        q, d;
    logic [RES_W-1:0] cur_bit, low_bit;

    always_comb begin
        d       = q;
        cur_bit = RES_W'(1) << q.idx;
        low_bit = cur_bit >> 1;
        if (flag_clr) d.flag = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_req && !stop_req) begin
                    d.st    = ST_WAIT;
                    d.go    = 1'b1;
                    d.hold  = 1'b1;
                    d.trial = '0;
                end
            end
            ST_WAIT: begin
                if (tick) begin
                    d.st  = ST_CONV;
                    d.idx = IDX_W'(RES_W);
                end
            end
            ST_CONV: begin
                if (tick) begin
                    if (q.idx == IDX_W'(RES_W)) begin
                        d.trial = RES_W'(1) << (RES_W - 1);
                        d.idx   = IDX_W'(RES_W - 1);
                    end else begin
                        d.trial = (cmp_hi ? q.trial : (q.trial & ~cur_bit)) | low_bit;
                        if (q.idx == '0) d.st  = ST_FIN;
                        else             d.idx = q.idx - IDX_W'(1);
                    end
                end
            end
            ST_FIN: begin
                d.res  = q.trial;
                d.go   = 1'b0;
                d.hold = 1'b0;
                d.flag = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
        if (stop_req && q.st != ST_IDLE) begin
            d.st   = ST_IDLE;
            d.go   = 1'b0;
            d.hold = 1'b0;
            d.flag = q.flag && !flag_clr;
            d.res  = q.res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign go        = q.go;
    assign hold_open = q.hold;
    assign done_flag = q.flag;
    assign dac_code  = q.trial;
    assign result    = q.res;

    assert_update_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> (!go && !hold_open && $past(go)));

    assert_result_only_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> ($fell(go) && done_flag));

    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CONV && start_req && !stop_req && !tick) |=> ($stable(dac_code) && go));

    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && go) |=> (!go && !hold_open && $stable(result)));

    assert_open_with_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go) |-> $rose(hold_open));

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int MAX_SHIFT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       clk_sel,
    input  logic             sys_halt,
    input  logic             rc_tick,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             flag_clr,
    input  logic             cmp_hi,
    output logic             go,
    output logic             hold_open,
    output logic [RES_W-1:0] dac_code,
    output logic             done_flag,
    output logic [7:0]       res_hi,
    output logic [7:0]       res_lo
);
    localparam int HI_W = RES_W - 8;

    logic             conv_tick;
    logic [RES_W-1:0] result;

    sar_clkgen #(.MAX_SHIFT(MAX_SHIFT)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sel   (clk_sel),
        .sys_halt  (sys_halt),
        .rc_tick   (rc_tick),
        .conv_tick (conv_tick)
    );

    sar_seq_core #(.RES_W(RES_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (conv_tick),
        .start_req (start_req),
        .stop_req  (stop_req),
        .flag_clr  (flag_clr),
        .cmp_hi    (cmp_hi),
        .go        (go),
        .hold_open (hold_open),
        .done_flag (done_flag),
        .dac_code  (dac_code),
        .result    (result)
    );

    assign res_lo = result[7:0];
    assign res_hi = {{(8 - HI_W){1'b0}}, result[RES_W-1:8]};

endmodule

// File: tb/sim_sar_conv_ctrl.sv
module sim_sar_conv_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] clk_sel;
    logic       sys_halt, rc_tick, start_req, stop_req, flag_clr;
    logic [9:0] vin;
    logic       cmp_hi;
    logic       go, hold_open, done_flag;
    logic [9:0] dac_code;
    logic [7:0] res_hi, res_lo;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    assign cmp_hi = (vin >= dac_code);

    sar_conv_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .sys_halt(sys_halt),
        .rc_tick(rc_tick), .start_req(start_req), .stop_req(stop_req),
        .flag_clr(flag_clr), .cmp_hi(cmp_hi), .go(go), .hold_open(hold_open),
        .dac_code(dac_code), .done_flag(done_flag), .res_hi(res_hi), .res_lo(res_lo)
    );

    function automatic int res_val();
        return {res_hi[1:0], res_lo};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_rc();
        rc_tick = 1'b1; @(negedge clk); rc_tick = 1'b0;
    endtask

    task automatic start_conv();
        start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic test_reset();
        check(go == 0 && hold_open == 0, "R11 go/hold", {go, hold_open}, 0);
        check(done_flag == 0 && dac_code == 0, "R11 flag/dac", int'(dac_code), 0);
        check(res_hi == 0 && res_lo == 0, "R11 result", res_val(), 0);
    endtask

    task automatic test_rc_frame();
        clk_sel = 3'b011; vin = 10'h2A5;
        clear_flag();
        start_conv();
        check(go == 1 && hold_open == 1, "R4 open at start", hold_open, 1);
        pulse_rc();
        check(dac_code == 0, "R2 first tick stages nothing", int'(dac_code), 0);
        pulse_rc();
        check(dac_code == 10'h200, "R3 top trial bit", int'(dac_code), 'h200);
        pulse_rc();
        check(dac_code == 10'h300, "R3 keep b9 set b8", int'(dac_code), 'h300);
        pulse_rc();
        check(dac_code == 10'h280, "R3 drop b8 set b7", int'(dac_code), 'h280);
        for (int i = 0; i < 8; i++) pulse_rc();
        check(go == 1 && done_flag == 0, "R2 not done at 12th tick", done_flag, 0);
        @(negedge clk);
        check(done_flag == 1 && go == 0 && hold_open == 0, "R5 end update",
              {done_flag, go, hold_open}, 4);
        check(res_hi == 8'h02, "R6 upper byte", res_hi, 2);
        check(res_lo == 8'hA5, "R6 lower byte", res_lo, 'hA5);
    endtask

    task automatic rc_convert(input logic [9:0] v, input string req);
        vin = v;
        clear_flag();
        start_conv();
        for (int i = 0; i < 12; i++) pulse_rc();
        @(negedge clk);
        check(done_flag == 1 && go == 0, {req, " done"}, done_flag, 1);
        check(res_val() == int'(v), {req, " value"}, res_val(), int'(v));
    endtask

    task automatic test_divider(input logic [2:0] code, input int div);
        int n = 0;
        clk_sel = code; vin = 10'(div * 13 + 7);
        clear_flag();
        start_conv();
        while (!done_flag && n < 3000) begin
            @(negedge clk); n++;
        end
        check(n >= 11 * div + 2 && n <= 12 * div + 1, "R1 R2 divider latency", n, 11 * div + 2);
        check(res_val() == int'(vin), "R3 divider result", res_val(), int'(vin));
    endtask

    task automatic test_halt();
        sys_halt = 1'b1; clk_sel = 3'b000;
        clear_flag();
        start_conv();
        repeat (300) @(negedge clk);
        check(go == 1 && done_flag == 0 && dac_code == 0, "R9 divider stalled",
              int'(dac_code), 0);
        stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
        check(go == 0, "R8 abort stalled conversion", go, 0);
        clk_sel = 3'b111;
        rc_convert(10'h3C1, "R9 rc while halted");
        sys_halt = 1'b0;
    endtask

    task automatic test_ignore();
        clk_sel = 3'b011; vin = 10'h155;
        clear_flag();
        start_conv();
        for (int i = 0; i < 5; i++) pulse_rc();
        start_conv();
        for (int i = 0; i < 6; i++) pulse_rc();
        check(done_flag == 0 && go == 1, "R7 schedule unchanged", done_flag, 0);
        pulse_rc();
        @(negedge clk);
        check(done_flag == 1 && res_val() == 'h155, "R7 completes", res_val(), 'h155);
    endtask

    task automatic test_abort();
        int prev;
        clk_sel = 3'b011;
        rc_convert(10'h0F0, "R3 mid value");
        prev = res_val();
        clear_flag();
        vin = 10'h333;
        start_conv();
        for (int i = 0; i < 6; i++) pulse_rc();
        stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
        check(go == 0 && hold_open == 0, "R8 abort clears go/hold", {go, hold_open}, 0);
        for (int i = 0; i < 12; i++) pulse_rc();
        @(negedge clk);
        check(done_flag == 0, "R8 flag untouched", done_flag, 0);
        check(res_val() == prev, "R8 result untouched", res_val(), prev);
    endtask

    task automatic test_flag();
        clk_sel = 3'b011;
        rc_convert(10'h001, "R3 small value");
        repeat (20) @(negedge clk);
        check(done_flag == 1, "R10 flag held", done_flag, 1);
        clear_flag();
        check(done_flag == 0, "R10 flag cleared", done_flag, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; clk_sel = 3'b000; sys_halt = 1'b0; rc_tick = 1'b0;
        start_req = 1'b0; stop_req = 1'b0; flag_clr = 1'b0; vin = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_rc_frame();
        clk_sel = 3'b011;
        rc_convert(10'h000, "R3 zero");
        rc_convert(10'h3FF, "R3 full scale");
        rc_convert(10'h2AA, "R3 R6 pattern");
        test_divider(3'b000, 2);
        test_divider(3'b100, 4);
        test_divider(3'b001, 8);
        test_divider(3'b101, 16);
        test_divider(3'b010, 32);
        test_divider(3'b110, 64);
        test_halt();
        test_ignore();
        test_abort();
        test_flag();
        finish_run();
    end
endmodule